// File: doc/BRIEF.md
# Paged Packet Memory Pointer Port

This block gives a host one-byte access into a small paged packet store. The host sets a 16-bit pointer register by writing its low and high bytes separately. It then reads or writes packet bytes through a four-address data window. The pointer's low eleven bits are a byte offset inside a 2048-byte page. Bit 15 picks where the page number comes from: either the packet number driven by the host-side logic, or the entry at the head of the receive queue. Both page numbers arrive on input pins.

Bit 14 of the pointer picks between two ways of walking a page. With bit 14 clear, the window acts as four adjacent bytes: the low two address bits are added to the offset and the pointer is left alone. With bit 14 set, every window access uses the current offset and then advances it by one, wrapping inside the page. The store is four pages by default. It is built as four byte-lane RAMs so that block RAM can be inferred. Read data is registered and appears on the cycle after the access.

Top module: `pbp_port`

## Requirements
- R1: After reset the pointer is 0x0000, so both pointer bytes read back as 0x00, and the read data output is 0x00.
- R2: A write to address 0 replaces pointer bits 7:0 and leaves bits 15:8 unchanged.
- R3: A write to address 1 replaces pointer bits 15:8 and leaves bits 7:0 unchanged.
- R4: A read of address 1 returns pointer bits 15:8 with bit 3 of that byte forced to zero (value AND 0xF7). A read of address 0 returns bits 7:0 unaltered.
- R5: A window access (address 4 to 7) uses page `rxq_head` when pointer bit 15 is 1 and page `pkt_sel` when it is 0.
- R6: With pointer bit 14 at 0, a window access at address 4+k (k = 0..3) reaches offset (pointer bits 10:0 + k) and leaves the pointer unchanged.
- R7: With pointer bit 14 at 1, a window access reaches the offset in pointer bits 10:0 and ignores address bits 1:0. Afterwards bits 10:0 hold that offset plus one and bits 15:11 are unchanged.
- R8: Offsets wrap modulo 2048 within the selected page in both modes. An auto-increment from 0x7FF gives 0x000, and an offset sum past 0x7FF wraps to the page start.
- R9: The result of a read is on `acc_rdata` from the clock edge that accepts the read until the next read. Writes and idle cycles leave it unchanged.
- R10: Addresses 2 and 3 read as 0x00, and writes to them change no state.
- R11: Each page stores its own bytes, so a write at an offset of one page does not change the same offset in another page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | 0 pointer low, 1 pointer high, 4..7 data window |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Registered read byte |
| pkt_sel | input | 2 | Page from the host packet number |
| rxq_head | input | 2 | Page at the head of the receive queue |

## Verification
The assertions assume that `pkt_sel` and `rxq_head` are stable valid page numbers whenever a window access is made. They also assume that at most one access occurs per cycle, with `acc_wr` qualifying it. The stimulus drives every input half a cycle away from the sampling edge and changes the page inputs only together with a new access. It never reads a byte that has not been written first, so every expected read value is defined.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int PTR_W       = 16;
  localparam int SRC_BIT     = 15;
  localparam int INC_BIT     = 14;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  localparam logic [2:0] A_PTR_LO = 3'd0;
  localparam logic [2:0] A_PTR_HI = 3'd1;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_PTR  = 2'd1,
    RSEL_MEM  = 2'd2
  } rsel_e;
endpackage

// File: rtl/pbp_ptr_reg.sv
module pbp_ptr_reg #(
  parameter int PAGE_AW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  input  logic        step,
  output logic [15:0] ptr
);
  localparam logic [PAGE_AW-1:0] ONE = PAGE_AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr[7:0] <= wdata;
    end else if (wr_hi) begin
      ptr[15:8] <= wdata;
    end else if (step) begin
      ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + ONE;
    end
  end
endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11
) (
  input  logic [PAGE_AW-1:0]                 off_in,
  input  logic                               use_rxq,
  input  logic                               auto_inc,
  input  logic [1:0]                         lane_sel,
  input  logic [$clog2(PAGES)-1:0]           pkt_sel,
  input  logic [$clog2(PAGES)-1:0]           rxq_head,
  output logic [$clog2(PAGES)+PAGE_AW-1:0]   byte_addr
);
  logic [PAGE_AW-1:0]       off;
  logic [$clog2(PAGES)-1:0] page;

  always_comb begin
    if (auto_inc) off = off_in;
    else          off = off_in + {{(PAGE_AW-2){1'b0}}, lane_sel};
    page      = use_rxq ? rxq_head : pkt_sel;
    byte_addr = {page, off};
  end
endmodule

// File: rtl/pbp_mem.sv
module pbp_mem #(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11,
  parameter int DW      = 8,
  parameter int LANES   = 4
) (
  input  logic                                clk,
  input  logic                                we,
  input  logic                                re,
  input  logic [$clog2(PAGES)+PAGE_AW-1:0]    byte_addr,
  input  logic [DW-1:0]                       wdata,
  output logic [DW-1:0]                       rbyte
);
  localparam int LANE_W = $clog2(LANES);
  localparam int AB     = $clog2(PAGES) + PAGE_AW;
  localparam int WORDS  = (PAGES << PAGE_AW) / LANES;

  logic [AB-LANE_W-1:0] word;
  logic [LANE_W-1:0]    lane;
  logic [LANE_W-1:0]    lane_r;
  logic [DW-1:0]        lane_q [LANES];

  assign word = byte_addr[AB-1:LANE_W];
  assign lane = byte_addr[LANE_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] ram [WORDS];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we && lane == LANE_W'(g)) ram[word] <= wdata;
      if (re) q <= ram[word];
    end
    assign lane_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (re) lane_r <= lane;
  end

  assign rbyte = lane_q[lane_r];
endmodule

// File: rtl/pbp_port.sv
module pbp_port #(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_en,
  input  logic                       acc_wr,
  input  logic [2:0]                 acc_addr,
  input  logic [7:0]                 acc_wdata,
  output logic [7:0]                 acc_rdata,
  input  logic [$clog2(PAGES)-1:0]   pkt_sel,
  input  logic [$clog2(PAGES)-1:0]   rxq_head
);
  import pbp_pkg::*;

  localparam int AB = $clog2(PAGES) + PAGE_AW;

  logic [15:0]   ptr_q;
  logic          win, wr_lo, wr_hi, step, rd;
  logic [AB-1:0] byte_addr;
  logic [7:0]    mem_byte;
  logic [7:0]    pbyte_q;
  rsel_e         rsel_q;

  assign win   = acc_en && acc_addr[2];
  assign rd    = acc_en && !acc_wr;
  assign wr_lo = acc_en && acc_wr && acc_addr == A_PTR_LO;
  assign wr_hi = acc_en && acc_wr && acc_addr == A_PTR_HI;
  assign step  = win && ptr_q[INC_BIT];

  pbp_ptr_reg #(.PAGE_AW(PAGE_AW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (acc_wdata),
    .step  (step),
    .ptr   (ptr_q)
  );

  pbp_addr_gen #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_agen (
    .off_in    (ptr_q[PAGE_AW-1:0]),
    .use_rxq   (ptr_q[SRC_BIT]),
    .auto_inc  (ptr_q[INC_BIT]),
    .lane_sel  (acc_addr[1:0]),
    .pkt_sel   (pkt_sel),
    .rxq_head  (rxq_head),
    .byte_addr (byte_addr)
  );

  pbp_mem #(.PAGES(PAGES), .PAGE_AW(PAGE_AW), .DW(8), .LANES(4)) u_mem (
    .clk       (clk),
    .we        (win && acc_wr),
    .re        (win && !acc_wr),
    .byte_addr (byte_addr),
    .wdata     (acc_wdata),
    .rbyte     (mem_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= RSEL_ZERO;
      pbyte_q <= '0;
    end else if (rd) begin
      if (acc_addr[2]) begin
        rsel_q <= RSEL_MEM;
      end else if (acc_addr == A_PTR_LO) begin
        rsel_q  <= RSEL_PTR;
        pbyte_q <= ptr_q[7:0];
      end else if (acc_addr == A_PTR_HI) begin
        rsel_q  <= RSEL_PTR;
        pbyte_q <= ptr_q[15:8] & HI_RD_MASK;
      end else begin
        rsel_q <= RSEL_ZERO;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_PTR: acc_rdata = pbyte_q;
      RSEL_MEM: acc_rdata = mem_byte;
      default:  acc_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/pbp_port_chk.sv
module pbp_port_chk #(
  parameter int PAGE_AW = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        acc_en,
  input logic        acc_wr,
  input logic [2:0]  acc_addr,
  input logic [7:0]  acc_rdata,
  input logic [15:0] ptr_q
);
  localparam logic [PAGE_AW-1:0] ONE = PAGE_AW'(1);

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_wr && acc_addr == 3'd0 |=> ptr_q[15:8] == $past(ptr_q[15:8])); // R2

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_wr && acc_addr == 3'd1 |=> ptr_q[7:0] == $past(ptr_q[7:0])); // R3

  AST_HI_BIT3_ZERO: assert property (@(posedge clk) disable iff (rst)
    acc_en && !acc_wr && acc_addr == 3'd1 |=> acc_rdata[3] == 1'b0); // R4

  AST_NOINC_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_addr[2] && !ptr_q[14] |=> $stable(ptr_q)); // R6

  AST_INC_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_addr[2] && ptr_q[14] |=>
      ptr_q[PAGE_AW-1:0] == $past(ptr_q[PAGE_AW-1:0]) + ONE); // R7

  AST_INC_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_addr[2] && ptr_q[14] |=>
      ptr_q[15:PAGE_AW] == $past(ptr_q[15:PAGE_AW])); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && !acc_wr) |=> $stable(acc_rdata)); // R9

  AST_GAP_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    acc_en && acc_wr && acc_addr[2:1] == 2'b01 |=> $stable(ptr_q)); // R10
endmodule

bind pbp_port pbp_port_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .ptr_q     (ptr_q)
);

// File: tb/pbp_port_test.sv
`timescale 1ns/1ps
module pbp_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [1:0] pkt_sel = '0;
  logic [1:0] rxq_head = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pbp_port uut (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .pkt_sel   (pkt_sel),
    .rxq_head  (rxq_head)
  );

  // Row layout: {req[4], chk, exp[8], wr, addr[3], wdata[8], pkt[2], rxq[2]}
  localparam int NV = 40;
  localparam logic [28:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h00, 1'b1, 3'd0, 8'h00, 2'd0, 2'd0}, // R2 ptr lo = 00
    {4'd3,  1'b0, 8'h00, 1'b1, 3'd1, 8'h00, 2'd0, 2'd0}, // R3 ptr hi = 00
    {4'd6,  1'b0, 8'h00, 1'b1, 3'd4, 8'hA0, 2'd0, 2'd0}, // R6 [0][0]
    {4'd6,  1'b0, 8'h00, 1'b1, 3'd5, 8'hA1, 2'd0, 2'd0}, // R6 [0][1]
    {4'd6,  1'b0, 8'h00, 1'b1, 3'd7, 8'hA3, 2'd0, 2'd0}, // R6 [0][3]
    {4'd11, 1'b0, 8'h00, 1'b1, 3'd4, 8'hB0, 2'd1, 2'd0}, // R11 [1][0]
    {4'd6,  1'b1, 8'hA0, 1'b0, 3'd4, 8'h00, 2'd0, 2'd0}, // R6
    {4'd6,  1'b1, 8'hA1, 1'b0, 3'd5, 8'h00, 2'd0, 2'd0}, // R6
    {4'd6,  1'b1, 8'hA3, 1'b0, 3'd7, 8'h00, 2'd0, 2'd0}, // R6
    {4'd11, 1'b1, 8'hB0, 1'b0, 3'd4, 8'h00, 2'd1, 2'd0}, // R11
    {4'd6,  1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R6 pointer untouched
    {4'd5,  1'b0, 8'h00, 1'b1, 3'd1, 8'h80, 2'd0, 2'd0}, // R5 source = rx queue
    {4'd5,  1'b1, 8'hB0, 1'b0, 3'd4, 8'h00, 2'd0, 2'd1}, // R5
    {4'd5,  1'b1, 8'hA0, 1'b0, 3'd4, 8'h00, 2'd1, 2'd0}, // R5
    {4'd2,  1'b0, 8'h00, 1'b1, 3'd0, 8'hFF, 2'd0, 2'd0}, // R2
    {4'd2,  1'b1, 8'h80, 1'b0, 3'd1, 8'h00, 2'd0, 2'd0}, // R2 high kept
    {4'd3,  1'b0, 8'h00, 1'b1, 3'd1, 8'h4F, 2'd0, 2'd0}, // R3
    {4'd3,  1'b1, 8'hFF, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R3 low kept
    {4'd4,  1'b1, 8'h47, 1'b0, 3'd1, 8'h00, 2'd0, 2'd0}, // R4 4F & F7
    {4'd7,  1'b0, 8'h00, 1'b1, 3'd6, 8'hC7, 2'd2, 2'd0}, // R7 [2][7FF]
    {4'd8,  1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R8 wrapped to 0
    {4'd8,  1'b1, 8'h40, 1'b0, 3'd1, 8'h00, 2'd0, 2'd0}, // R8 48 & F7
    {4'd7,  1'b0, 8'h00, 1'b1, 3'd4, 8'hC8, 2'd2, 2'd0}, // R7 [2][0]
    {4'd7,  1'b0, 8'h00, 1'b1, 3'd4, 8'hC9, 2'd2, 2'd0}, // R7 [2][1]
    {4'd7,  1'b1, 8'h02, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R7
    {4'd2,  1'b0, 8'h00, 1'b1, 3'd0, 8'hFE, 2'd0, 2'd0}, // R2
    {4'd3,  1'b0, 8'h00, 1'b1, 3'd1, 8'h07, 2'd0, 2'd0}, // R3 ptr = 07FE
    {4'd6,  1'b1, 8'hC7, 1'b0, 3'd5, 8'h00, 2'd2, 2'd0}, // R6 7FE+1
    {4'd8,  1'b1, 8'hC8, 1'b0, 3'd6, 8'h00, 2'd2, 2'd0}, // R8 7FE+2 wraps
    {4'd8,  1'b1, 8'hC9, 1'b0, 3'd7, 8'h00, 2'd2, 2'd0}, // R8 7FE+3 wraps
    {4'd3,  1'b0, 8'h00, 1'b1, 3'd1, 8'h47, 2'd0, 2'd0}, // R3
    {4'd2,  1'b0, 8'h00, 1'b1, 3'd0, 8'hFF, 2'd0, 2'd0}, // R2 ptr = 47FF
    {4'd7,  1'b1, 8'hC7, 1'b0, 3'd4, 8'h00, 2'd2, 2'd0}, // R7
    {4'd8,  1'b1, 8'hC8, 1'b0, 3'd4, 8'h00, 2'd2, 2'd0}, // R8
    {4'd7,  1'b1, 8'hC9, 1'b0, 3'd4, 8'h00, 2'd2, 2'd0}, // R7
    {4'd7,  1'b1, 8'h02, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R7
    {4'd10, 1'b1, 8'h00, 1'b0, 3'd2, 8'h00, 2'd0, 2'd0}, // R10 reads zero
    {4'd9,  1'b1, 8'h00, 1'b1, 3'd2, 8'h55, 2'd0, 2'd0}, // R9 held over write
    {4'd10, 1'b1, 8'h02, 1'b0, 3'd0, 8'h00, 2'd0, 2'd0}, // R10 ptr untouched
    {4'd10, 1'b1, 8'h40, 1'b0, 3'd1, 8'h00, 2'd0, 2'd0}  // R10
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // Drive one access at a falling edge; return at the next falling edge.
  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        input logic [1:0] pk, input logic [1:0] rq);
    acc_en    = 1'b1;
    acc_wr    = wr;
    acc_addr  = a;
    acc_wdata = d;
    pkt_sel   = pk;
    rxq_head  = rq;
    @(negedge clk);
    acc_en    = 1'b0;
    acc_wr    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, acc_rdata, 8'h00);                 // R1 output after reset
    access(1'b0, 3'd0, 8'h00, 2'd0, 2'd0);
    check(1, acc_rdata, 8'h00);                 // R1 pointer low
    access(1'b0, 3'd1, 8'h00, 2'd0, 2'd0);
    check(1, acc_rdata, 8'h00);                 // R1 pointer high

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][15], VEC[i][14:12], VEC[i][11:4], VEC[i][3:2], VEC[i][1:0]);
      if (VEC[i][24]) check(int'(VEC[i][28:25]), acc_rdata, VEC[i][23:16]);
    end

    // R9: idle cycles keep the last read value
    access(1'b0, 3'd1, 8'h00, 2'd0, 2'd0);
    repeat (3) @(negedge clk);
    check(9, acc_rdata, 8'h40);

    // R1: reset in the middle of traffic clears the pointer
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, acc_rdata, 8'h00);
    access(1'b0, 3'd1, 8'h00, 2'd0, 2'd0);
    check(1, acc_rdata, 8'h00);
    access(1'b0, 3'd0, 8'h00, 2'd0, 2'd0);
    check(1, acc_rdata, 8'h00);

    // R11: page 0 offset 0 still holds its own byte after page 1 and 2 writes
    access(1'b0, 3'd4, 8'h00, 2'd0, 2'd0);
    check(11, acc_rdata, 8'hA0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule